// File: doc/BRIEF.md
# Hilbert FIR Envelope Detector

This block extracts the amplitude envelope of a sampled radio-frequency echo stream at one sample per clock. Each accepted sample enters a tapped delay line. An odd-length Hilbert-transform FIR filter with antisymmetric coefficients produces the quadrature component. The centre tap of the same line gives the in-phase component, so I and Q are aligned to the filter's group delay without a separate delay path.

The filter's even-offset coefficients are zero and the others come in mirrored pairs of opposite sign. Only the odd offsets get hardware. Each pair is first subtracted and then multiplied once, so the default 15-tap filter uses four multipliers. The magnitude sqrt(I² + Q²) is formed by a squaring stage followed by a fully pipelined non-restoring integer square root. After the pipeline fills, the block delivers one envelope value per clock.

Samples are qualified by a valid strobe. The delay line advances only on valid samples. A matching valid shift register marks which outputs carry results.

Top module: `hilbert_envelope`

## Requirements
- R1: A synchronous active-low reset clears every delay-line and pipeline register. While reset is held, and on the cycle after it, `out_valid` is 0 and `out_env` is 0. Samples that arrive after reset see zeros in all older taps.
- R2: `out_valid` equals `in_valid` delayed by exactly 19 clock cycles. A sample presented in cycle t produces its envelope in cycle t+19.
- R3: Each valid input sample produces exactly one valid envelope value. A continuous input stream produces a valid output on every cycle once the pipeline has filled.
- R4: Let x[j] be the sample accepted j valid samples ago, with x[0] the sample presented now. I = x[7]. Q = floor((c1·(x[8]−x[6]) + c3·(x[10]−x[4]) + c5·(x[12]−x[2]) + c7·(x[14]−x[0])) / 2^14), clamped to the signed 16-bit range. The default coefficients are c1=10430, c3=3477, c5=2086 and c7=1490.
- R5: `out_env` = floor(sqrt(I² + Q²)) as an unsigned value, clamped to 65535.
- R6: A cycle with `in_valid` low does not move the delay line. The filter window always holds the most recent 15 valid samples.
- R7: When all 15 samples in the window hold the same value v, Q is 0 and the envelope equals |v|. This includes the negative full-scale input −8192, which gives 8192.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_sample` for this cycle |
| in_sample | input | 14 | Signed two's-complement RF sample |
| out_valid | output | 1 | Qualifies `out_env` |
| out_env | output | 16 | Unsigned envelope magnitude |

## Verification
Every result is due exactly 19 cycles after its sample. The pipeline has one pre-subtract register, one multiply-accumulate register, one sum-of-squares register and sixteen root registers. The bench model pushes each cycle's expected valid bit and envelope into a 19-deep array at the rising edge. It compares the oldest entry with the outputs at the following falling edge, so both the valid timing and the value are checked on every cycle. Directed checks read back the last output once the stream has drained: constant windows, and the first output after a mid-run reset, whose value is 46 for a lone sample of 500. Valid patterns with gaps confirm that idle cycles neither shift the window nor shorten the 19-cycle latency.

// File: rtl/hilbert_env_pkg.sv
// Package: shared defaults for the Hilbert envelope detector.
// Assumes coefficients are packed lowest odd offset first, CW bits each.
package hilbert_env_pkg;
    localparam int DEF_DW    = 14;
    localparam int DEF_CW    = 16;
    localparam int DEF_HALF  = 7;
    localparam int DEF_CFRAC = 14;
    localparam int DEF_QW    = 16;
    localparam int DEF_OW    = 16;
    // Offsets 1,3,5,7 of a truncated 2/(pi*k) response scaled by 2^14.
    localparam logic [4*DEF_CW-1:0] DEF_COEFS =
        {16'sd1490, 16'sd2086, 16'sd3477, 16'sd10430};
endpackage

// File: rtl/hilbert_tap_line.sv
// Module: shift register holding the DEPTH previous valid samples.
// Slice j of taps holds the sample accepted j+1 valid samples ago.
// Assumes DEPTH >= 2; advances only when shift_en is high.
module hilbert_tap_line #(
    parameter int DW    = 14,
    parameter int DEPTH = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic [DW-1:0]       din,
    output logic [DEPTH*DW-1:0] taps
);
    logic [DEPTH*DW-1:0] line_q;

    // Shift in the new sample on valid, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
        end else if (shift_en) begin
            line_q <= {line_q[(DEPTH-1)*DW-1:0], din};
        end
    end

    assign taps = line_q;
endmodule

// File: rtl/hilbert_quad_path.sv
// Module: produces aligned in-phase and quadrature values in two stages.
// Stage 1 subtracts mirrored taps at odd offsets from the centre and
// registers the centre sample; stage 2 multiplies, sums, rescales and
// clamps Q. Assumes HALF is odd so the outermost pair uses the live sample.
module hilbert_quad_path #(
    parameter int DW    = 14,
    parameter int CW    = 16,
    parameter int HALF  = 7,
    parameter int CFRAC = 14,
    parameter int QW    = 16,
    parameter int NNZ   = (HALF + 1) / 2,
    parameter logic [NNZ*CW-1:0] COEFS = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic signed [DW-1:0]       newest,
    input  logic [2*HALF*DW-1:0]       taps,
    output logic signed [DW-1:0]       i_out,
    output logic signed [QW-1:0]       q_out
);
    localparam int NWIN = 2 * HALF + 1;
    localparam int ACCW = DW + 1 + CW + $clog2(NNZ) + 1;
    localparam logic signed [ACCW-1:0] QMAX = {{(ACCW-QW+1){1'b0}}, {(QW-1){1'b1}}};
    localparam logic signed [ACCW-1:0] QMIN = ~QMAX;

    logic signed [DW-1:0]   win [NWIN];
    logic signed [DW:0]     pre_q [NNZ];
    logic signed [ACCW-1:0] prod [NNZ];
    logic signed [DW-1:0]   i_s1;
    logic signed [ACCW-1:0] acc;
    logic signed [ACCW-1:0] scaled;
    logic signed [QW-1:0]   q_sat;

    // Assemble the window: index 0 live, index j delayed j samples.
    always_comb begin
        win[0] = newest;
        for (int j = 1; j < NWIN; j++) begin
            win[j] = taps[(j-1)*DW +: DW];
        end
    end

    generate
        for (genvar g = 0; g < NNZ; g++) begin : g_pair
            localparam int OFS = 2 * g + 1;
            localparam logic signed [CW-1:0] CK = COEFS[g*CW +: CW];

            // Pre-subtract the older tap minus the newer tap of one pair.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pre_q[g] <= '0;
                end else begin
                    pre_q[g] <= (DW+1)'(win[HALF+OFS]) - (DW+1)'(win[HALF-OFS]);
                end
            end

            assign prod[g] = ACCW'(pre_q[g]) * ACCW'(CK);
        end
    endgenerate

    // Sum products, rescale by the coefficient fraction and clamp.
    always_comb begin
        acc = '0;
        for (int g = 0; g < NNZ; g++) begin
            acc = acc + prod[g];
        end
        scaled = acc >>> CFRAC;
        if (scaled > QMAX) begin
            q_sat = QMAX[QW-1:0];
        end else if (scaled < QMIN) begin
            q_sat = QMIN[QW-1:0];
        end else begin
            q_sat = scaled[QW-1:0];
        end
    end

    // Register the centre sample, then emit I and Q together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i_s1  <= '0;
            i_out <= '0;
            q_out <= '0;
        end else begin
            i_s1  <= win[HALF];
            i_out <= i_s1;
            q_out <= q_sat;
        end
    end
endmodule

// File: rtl/hilbert_mag.sv
// Module: magnitude sqrt(I^2 + Q^2) with one squaring stage and RW
// non-restoring root stages (one result bit per stage), then clamps to OW.
// Assumes DW < QW so the sum of squares fits a 2*QW-bit radicand.
module hilbert_mag #(
    parameter int DW = 14,
    parameter int QW = 16,
    parameter int OW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] i_in,
    input  logic signed [QW-1:0] q_in,
    output logic [OW-1:0]        env
);
    localparam int RW   = QW;
    localparam int RADW = 2 * QW;
    localparam int REMW = RW + 4;

    logic signed [QW-1:0]   i_ext;
    logic signed [RADW-1:0] ii;
    logic signed [RADW-1:0] qq;
    logic [RADW-1:0]        rad_q  [RW];
    logic signed [REMW-1:0] rem_q  [RW];
    logic [RW-1:0]          root_q [RW+1];

    assign i_ext = QW'(i_in);
    assign ii    = i_ext * i_ext;
    assign qq    = q_in * q_in;

    // Register the sum of squares as the radicand.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rad_q[0] <= '0;
        end else begin
            rad_q[0] <= RADW'(ii + qq);
        end
    end

    assign rem_q[0]  = '0;
    assign root_q[0] = '0;

    generate
        for (genvar s = 0; s < RW; s++) begin : g_root
            localparam int BIT = 2 * (RW - 1 - s);
            logic signed [REMW-1:0] shifted;
            logic signed [REMW-1:0] nrem;

            // One non-restoring step: bring down two bits, add or subtract.
            always_comb begin
                shifted = (rem_q[s] <<< 2) + REMW'({1'b0, rad_q[s][BIT +: 2]});
                if (rem_q[s] >= 0) begin
                    nrem = shifted - REMW'({1'b0, root_q[s], 2'b01});
                end else begin
                    nrem = shifted + REMW'({1'b0, root_q[s], 2'b11});
                end
            end

            // Append the new root bit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    root_q[s+1] <= '0;
                end else begin
                    root_q[s+1] <= {root_q[s][RW-2:0], ~nrem[REMW-1]};
                end
            end

            if (s < RW - 1) begin : g_carry
                // Carry the radicand and partial remainder to the next step.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        rad_q[s+1] <= '0;
                        rem_q[s+1] <= '0;
                    end else begin
                        rad_q[s+1] <= rad_q[s];
                        rem_q[s+1] <= nrem;
                    end
                end
            end
        end

        if (RW > OW) begin : g_clamp
            assign env = (root_q[RW] > RW'({OW{1'b1}})) ? {OW{1'b1}} : root_q[RW][OW-1:0];
        end else begin : g_widen
            assign env = OW'(root_q[RW]);
        end
    endgenerate
endmodule

// File: rtl/hilbert_envelope.sv
// Module: top of the Hilbert FIR envelope detector.
// One signed sample per clock in and one envelope per clock out, with a
// fixed latency of 3 + QW cycles (19 at defaults). Assumes HALF odd, DW < QW.
module hilbert_envelope
    import hilbert_env_pkg::*;
#(
    parameter int DW    = DEF_DW,
    parameter int CW    = DEF_CW,
    parameter int HALF  = DEF_HALF,
    parameter int CFRAC = DEF_CFRAC,
    parameter int QW    = DEF_QW,
    parameter int OW    = DEF_OW,
    parameter int NNZ   = (HALF + 1) / 2,
    parameter logic [NNZ*CW-1:0] COEFS = DEF_COEFS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_sample,
    output logic                 out_valid,
    output logic [OW-1:0]        out_env
);
    localparam int NT  = 2 * HALF;
    localparam int LAT = 3 + QW;

    logic [NT*DW-1:0]     tap_bus;
    logic signed [DW-1:0] i_al;
    logic signed [QW-1:0] q_al;
    logic [LAT-1:0]       vld_sr;

    hilbert_tap_line #(.DW(DW), .DEPTH(NT)) u_taps (
        .clk(clk), .rst_n(rst_n), .shift_en(in_valid),
        .din(in_sample), .taps(tap_bus)
    );

    hilbert_quad_path #(
        .DW(DW), .CW(CW), .HALF(HALF), .CFRAC(CFRAC),
        .QW(QW), .NNZ(NNZ), .COEFS(COEFS)
    ) u_quad (
        .clk(clk), .rst_n(rst_n), .newest(in_sample),
        .taps(tap_bus), .i_out(i_al), .q_out(q_al)
    );

    hilbert_mag #(.DW(DW), .QW(QW), .OW(OW)) u_mag (
        .clk(clk), .rst_n(rst_n), .i_in(i_al), .q_in(q_al), .env(out_env)
    );

    // Carry the valid strobe alongside the data pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_sr <= '0;
        end else begin
            vld_sr <= {vld_sr[LAT-2:0], in_valid};
        end
    end

    assign out_valid = vld_sr[LAT-1];
endmodule

// File: rtl/hilbert_envelope_chk.sv
// Checker: temporal properties of the envelope detector, bound to the top.
// Keeps its own valid history to check the latency independently.
module hilbert_envelope_chk #(
    parameter int DW  = 14,
    parameter int NT  = 14,
    parameter int LAT = 19,
    parameter int OW  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [DW-1:0]    in_sample,
    input logic             out_valid,
    input logic [OW-1:0]    out_env,
    input logic [NT*DW-1:0] tap_bus
);
    logic [LAT-1:0] ref_sr;

    // Independent record of input valids for the latency check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_sr <= '0;
        end else begin
            ref_sr <= {ref_sr[LAT-2:0], in_valid};
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_env == '0));

    a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == ref_sr[LAT-1]);

    a_r6_hold_on_gap: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(tap_bus));

    a_r6_load_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> tap_bus[DW-1:0] == $past(in_sample));
endmodule

bind hilbert_envelope hilbert_envelope_chk #(
    .DW(DW), .NT(2*HALF), .LAT(3+QW), .OW(OW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_env(out_env), .tap_bus(tap_bus)
);

// File: tb/hilbert_envelope_test.sv
// Bench: behavioural model (sample history, 19-deep result queue) compared
// with the outputs on every falling edge, plus directed corner checks.
module hilbert_envelope_test;
    localparam int LATENCY = 19;
    localparam int HALF    = 7;
    localparam int WIN     = 2 * HALF + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [13:0] in_sample = '0;
    logic        out_valid;
    logic [15:0] out_env;

    int checks = 0;
    int errors = 0;
    int in_cnt = 0;
    int out_cnt = 0;
    int cycles = 0;
    bit done = 0;
    bit cap_first = 0;
    longint first_env = -1;
    longint last_env = -1;
    string phase = "R5 idle";

    longint hist [WIN];
    bit     pv [LATENCY];
    longint pe [LATENCY];
    longint coef [4] = '{10430, 3477, 2086, 1490};

    hilbert_envelope uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid), .out_env(out_env)
    );

    always #10 clk = ~clk;

    function automatic longint isqrt(input longint v);
        longint r = 0;
        for (int b = 16; b >= 0; b--) begin
            longint t = r | (longint'(1) << b);
            if (t * t <= v) r = t;
        end
        return r;
    endfunction

    // R4 R5: envelope of the current window, from the requirement formulas.
    function automatic longint model_env();
        longint acc = 0;
        longint q, i, e;
        for (int g = 0; g < 4; g++) begin
            int k = 2 * g + 1;
            acc += coef[g] * (hist[HALF+k] - hist[HALF-k]);
        end
        q = acc >>> 14;
        if (q > 32767) q = 32767;
        if (q < -32768) q = -32768;
        i = hist[HALF];
        e = isqrt(i * i + q * q);
        if (e > 65535) e = 65535;
        return e;
    endfunction

    // Model update at each rising edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            for (int j = 0; j < WIN; j++) hist[j] = 0;
            for (int j = 0; j < LATENCY; j++) begin pv[j] = 0; pe[j] = 0; end
        end else begin
            for (int j = LATENCY - 1; j > 0; j--) begin pv[j] = pv[j-1]; pe[j] = pe[j-1]; end
            pv[0] = in_valid;
            pe[0] = 0;
            if (in_valid) begin
                in_cnt++;
                for (int j = WIN - 1; j > 0; j--) hist[j] = hist[j-1];
                hist[0] = longint'($signed(in_sample));
                pe[0] = model_env();
            end
        end
    end

    // Compare outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (out_valid !== pv[LATENCY-1]) begin
                errors++;
                $display("FAIL R2 (%s) out_valid actual %0b expected %0b", phase, out_valid, pv[LATENCY-1]);
            end
            if (out_valid === 1'b1) begin
                out_cnt++;
                last_env = longint'(out_env);
                if (cap_first) begin first_env = longint'(out_env); cap_first = 0; end
                if (pv[LATENCY-1]) begin
                    checks++;
                    if (longint'(out_env) != pe[LATENCY-1]) begin
                        errors++;
                        $display("FAIL R5 (%s) out_env actual %0d expected %0d", phase, out_env, pe[LATENCY-1]);
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cycles > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog actual %0d cycles expected under 150000", cycles);
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic drive(input bit v, input int x);
        @(negedge clk);
        in_valid = v;
        in_sample = 14'(x);
    endtask

    task automatic drain();
        for (int n = 0; n < LATENCY + 4; n++) drive(0, 0);
    endtask

    task automatic check_val(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        // R1: reset state while reset is held.
        repeat (3) @(negedge clk);
        check_val("R1 out_valid in reset", longint'(out_valid), 0);
        check_val("R1 out_env in reset", longint'(out_env), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4: impulse exposes each coefficient pair in turn.
        phase = "R4 impulse";
        drive(1, 4000);
        for (int n = 0; n < 20; n++) drive(1, 0);
        drive(1, -4000);
        for (int n = 0; n < 20; n++) drive(1, 0);
        drain();

        // R7: constant windows cancel Q.
        phase = "R7 constant";
        for (int n = 0; n < 30; n++) drive(1, 1000);
        drain();
        check_val("R7 constant 1000", last_env, 1000);
        for (int n = 0; n < 30; n++) drive(1, -8192);
        drain();
        check_val("R7 constant -8192", last_env, 8192);

        // R3: continuous sinusoid-like stream, one output per clock.
        phase = "R3 tone";
        for (int n = 0; n < 200; n++)
            drive(1, int'($rtoi(6000.0 * $sin(6.2831853 * n / 8.0))));
        drain();

        // R6: random data with random gaps.
        phase = "R6 gaps";
        for (int n = 0; n < 400; n++)
            drive(($urandom % 3) != 0, int'($urandom % 16384) - 8192);
        drain();

        // R4: extreme alternating values stress Q width.
        phase = "R4 extremes";
        for (int n = 0; n < 60; n++) drive(1, (n % 2 == 0) ? 8191 : -8192);
        for (int n = 0; n < 60; n++) drive(1, ((n / 7) % 2 == 0) ? 8191 : -8192);
        drain();

        check_val("R3 outputs equal inputs", longint'(out_cnt), longint'(in_cnt));

        // R1: mid-run reset clears history; a lone 500 gives floor(sqrt(46^2)).
        phase = "R1 after reset";
        for (int n = 0; n < 10; n++) drive(1, 7000);
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        check_val("R1 out_valid after reset", longint'(out_valid), 0);
        check_val("R1 out_env after reset", longint'(out_env), 0);
        rst_n = 1'b1;
        cap_first = 1;
        drive(1, 500);
        drain();
        check_val("R1 first output after reset", first_env, 46);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule